// File: doc/BRIEF.md
# DMA Channel Credit Flow-Control Endpoint

This block sits on the DMA side of a credit link to a memory agent in programmable logic. The agent offers credits by raising a credit-valid line. The block takes a credit in every cycle where that line is high and its own acknowledge output is low. It keeps a count of banked credits, up to a ceiling of 32. It raises its acknowledge output while the bank is full, so that no credit is taken past the ceiling.

Each banked credit allows exactly one bus transaction on the metered side. A configuration bit picks that side: either source reads from the agent's memory or destination writes into it. A launch request on the metered side is granted only while the bank holds a credit, and each grant spends one credit. A request on the other side is granted without touching the bank.

Finished transactions on the metered side are reported back to the agent. A read counts as finished when its data has been received. A write counts as finished when its write response has come back. The block queues each finished transaction and raises transaction-valid until the agent acknowledges each one in turn. Clearing the enable input empties the bank and the queue and drives every output low.

Top module: `dma_credit_link`

## Requirements
- R1: After reset the credit count is 0, and `crd_ack_o`, `txn_valid_o` and both grants are low. A metered request made straight after reset is refused.
- R2: While enabled, a cycle with `crd_valid_i` high and `crd_ack_o` low raises the count by one at the next clock edge, provided no metered grant is made in that cycle.
- R3: The count never exceeds 32. While the count is 32 and the block is enabled, `crd_ack_o` is high and `crd_valid_i` has no effect on the count.
- R4: `cfg_dir_write` selects the metered side: 0 meters `rd_req_i` and 1 meters `wr_req_i`. A metered request is granted in the same cycle only when the count is nonzero, and each grant lowers the count by one at the next edge.
- R5: When a credit is accepted and a metered grant is made in the same cycle, the count is unchanged.
- R6: A request on the unmetered side is granted in the same cycle whenever the block is enabled, and it leaves the count unchanged.
- R7: Each completion on the metered side adds one pending completion. The completion strobe is `rd_done_i` in read mode (0) and `wr_resp_i` in write mode (1). The strobe of the other side is ignored.
- R8: `txn_valid_o` is high while any completion is pending, and it stays high until acknowledged. Each cycle with both `txn_valid_o` and `txn_ack_i` high removes one pending completion.
- R9: Several completions can be pending at once, and each one needs its own acknowledge cycle.
- R10: While `cfg_enable` is low, `crd_ack_o`, both grants and `txn_valid_o` are low. The count and the pending completions are zero after the next edge, so neither survives re-enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Enables the interface; when low, clears credits and pending completions |
| cfg_dir_write | input | 1 | Metered side: 0 = source reads, 1 = destination writes |
| crd_valid_i | input | 1 | Credit offered by the agent |
| crd_ack_o | output | 1 | High while the block refuses credits (bank full) |
| rd_req_i | input | 1 | Read launch request |
| rd_gnt_o | output | 1 | Read launch grant (same cycle) |
| wr_req_i | input | 1 | Write launch request |
| wr_gnt_o | output | 1 | Write launch grant (same cycle) |
| rd_done_i | input | 1 | Strobe: a read has finished |
| wr_resp_i | input | 1 | Strobe: a write response has been received |
| txn_valid_o | output | 1 | A finished transaction awaits acknowledge |
| txn_ack_i | input | 1 | Agent acknowledges one finished transaction |
| credit_count_o | output | 6 | Credits currently banked (0 to 32) |

## Verification
The credit counter is driven with a lone credit, a lone metered launch, and a credit together with a launch. These patterns separate the increment, the decrement and the net-zero case, so a counter that adds and subtracts in the wrong order is caught. Launches are tried with an empty bank and a full one, and on both sides in both modes. This separates metered from unmetered gating and shows that the mode bit really swaps the metered side. Completion strobes are sent on the metered side, on the ignored side, and several in a row before any acknowledge, which shows whether completions are filtered, queued or lost. The bank is filled to its ceiling under a steady credit offer, and the block is then disabled with credits and completions both outstanding.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

    // Selects which side of the channel consumes credits.
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dcl_dir_e;

    // Number of launch sides handled by the gate.
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/dcl_credit_ctr.sv
module dcl_credit_ctr #(
    parameter int MAX_CREDITS = 32,
    localparam int CW = $clog2(MAX_CREDITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          crd_valid,
    input  logic          spend,
    output logic          ack,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] CEIL = CW'(MAX_CREDITS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       full;
    logic       accept;

    always_comb begin
        full   = (st_q.cnt == CEIL);
        ack    = enable & full;
        accept = enable & crd_valid & ~ack;
        st_d   = st_q;
        if (!enable) begin
            st_d.cnt = '0;
        end else begin
            unique case ({accept, spend})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/dcl_launch_gate.sv
module dcl_launch_gate
    import dcl_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic                 enable,
    input  dcl_dir_e             dir,
    input  logic [CW-1:0]        count,
    input  logic [NUM_SIDES-1:0] req,
    output logic [NUM_SIDES-1:0] gnt,
    output logic                 spend
);

    logic                 have_credit;
    logic [NUM_SIDES-1:0] spend_vec;

    assign have_credit = (count != '0);

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        localparam dcl_dir_e SIDE = (g == 0) ? DIR_READ : DIR_WRITE;
        logic metered;
        always_comb begin
            metered      = (dir == SIDE);
            gnt[g]       = enable & req[g] & (~metered | have_credit);
            spend_vec[g] = gnt[g] & metered;
        end
    end

    assign spend = |spend_vec;

endmodule

// File: rtl/dcl_done_queue.sv
module dcl_done_queue
    import dcl_pkg::*;
#(
    parameter int PEND_DEPTH = 32,
    localparam int PW = $clog2(PEND_DEPTH + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  dcl_dir_e dir,
    input  logic     rd_done,
    input  logic     wr_resp,
    input  logic     txn_ack,
    output logic     txn_valid
);

    localparam logic [PW-1:0] PMAX = PW'(PEND_DEPTH);

    typedef struct packed {
        logic [PW-1:0] pend;
    } q_state_t;

    q_state_t st_d, st_q;
    logic     push;
    logic     pop;

    always_comb begin
        txn_valid = enable & (st_q.pend != '0);
        push      = enable & ((dir == DIR_READ) ? rd_done : wr_resp);
        pop       = txn_valid & txn_ack;
        st_d      = st_q;
        if (!enable) begin
            st_d.pend = '0;
        end else begin
            unique case ({push, pop})
                2'b10:   st_d.pend = (st_q.pend == PMAX) ? PMAX : st_q.pend + PW'(1);
                2'b01:   st_d.pend = st_q.pend - PW'(1);
                default: st_d.pend = st_q.pend;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dma_credit_link.sv
module dma_credit_link
    import dcl_pkg::*;
#(
    parameter int MAX_CREDITS = 32,
    parameter int PEND_DEPTH  = 32,
    localparam int CW = $clog2(MAX_CREDITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic          cfg_dir_write,
    input  logic          crd_valid_i,
    output logic          crd_ack_o,
    input  logic          rd_req_i,
    output logic          rd_gnt_o,
    input  logic          wr_req_i,
    output logic          wr_gnt_o,
    input  logic          rd_done_i,
    input  logic          wr_resp_i,
    output logic          txn_valid_o,
    input  logic          txn_ack_i,
    output logic [CW-1:0] credit_count_o
);

    dcl_dir_e             dir;
    logic [CW-1:0]        count;
    logic [NUM_SIDES-1:0] req;
    logic [NUM_SIDES-1:0] gnt;
    logic                 spend;

    assign dir = cfg_dir_write ? DIR_WRITE : DIR_READ;
    assign req = {wr_req_i, rd_req_i};

    dcl_credit_ctr #(
        .MAX_CREDITS (MAX_CREDITS)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .crd_valid (crd_valid_i),
        .spend     (spend),
        .ack       (crd_ack_o),
        .count     (count)
    );

    dcl_launch_gate #(
        .CW (CW)
    ) u_gate (
        .enable (cfg_enable),
        .dir    (dir),
        .count  (count),
        .req    (req),
        .gnt    (gnt),
        .spend  (spend)
    );

    dcl_done_queue #(
        .PEND_DEPTH (PEND_DEPTH)
    ) u_done (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .dir       (dir),
        .rd_done   (rd_done_i),
        .wr_resp   (wr_resp_i),
        .txn_ack   (txn_ack_i),
        .txn_valid (txn_valid_o)
    );

    assign rd_gnt_o       = gnt[0];
    assign wr_gnt_o       = gnt[1];
    assign credit_count_o = count;

endmodule

// File: rtl/dcl_checker.sv
module dcl_checker #(
    parameter int MAX_CREDITS = 32,
    localparam int CW = $clog2(MAX_CREDITS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_enable,
    input logic          cfg_dir_write,
    input logic          crd_valid_i,
    input logic          crd_ack_o,
    input logic          rd_gnt_o,
    input logic          wr_gnt_o,
    input logic          txn_valid_o,
    input logic          txn_ack_i,
    input logic [CW-1:0] credit_count_o
);

    logic metered_gnt;
    assign metered_gnt = cfg_dir_write ? wr_gnt_o : rd_gnt_o;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        credit_count_o <= CW'(MAX_CREDITS));

    assert_ack_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && credit_count_o == CW'(MAX_CREDITS)) |-> crd_ack_o);

    assert_credit_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && crd_valid_i && !crd_ack_o && !metered_gnt)
        |=> credit_count_o == $past(credit_count_o) + CW'(1));

    assert_grant_needs_credit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        metered_gnt |-> credit_count_o != '0);

    assert_valid_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && txn_valid_o && !txn_ack_i) |=> (txn_valid_o || !cfg_enable));

    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> (!crd_ack_o && !rd_gnt_o && !wr_gnt_o && !txn_valid_o));

    assert_cleared_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> credit_count_o == '0);

endmodule

bind dma_credit_link dcl_checker #(
    .MAX_CREDITS (MAX_CREDITS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_enable     (cfg_enable),
    .cfg_dir_write  (cfg_dir_write),
    .crd_valid_i    (crd_valid_i),
    .crd_ack_o      (crd_ack_o),
    .rd_gnt_o       (rd_gnt_o),
    .wr_gnt_o       (wr_gnt_o),
    .txn_valid_o    (txn_valid_o),
    .txn_ack_i      (txn_ack_i),
    .credit_count_o (credit_count_o)
);

// File: tb/dma_credit_link_tb.sv
module dma_credit_link_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0;
    logic       cfg_dir_write = 1'b0;
    logic       crd_valid_i = 1'b0;
    logic       rd_req_i = 1'b0;
    logic       wr_req_i = 1'b0;
    logic       rd_done_i = 1'b0;
    logic       wr_resp_i = 1'b0;
    logic       txn_ack_i = 1'b0;
    logic       crd_ack_o, rd_gnt_o, wr_gnt_o, txn_valid_o;
    logic [5:0] credit_count_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_credit_link u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_enable     (cfg_enable),
        .cfg_dir_write  (cfg_dir_write),
        .crd_valid_i    (crd_valid_i),
        .crd_ack_o      (crd_ack_o),
        .rd_req_i       (rd_req_i),
        .rd_gnt_o       (rd_gnt_o),
        .wr_req_i       (wr_req_i),
        .wr_gnt_o       (wr_gnt_o),
        .rd_done_i      (rd_done_i),
        .wr_resp_i      (wr_resp_i),
        .txn_valid_o    (txn_valid_o),
        .txn_ack_i      (txn_ack_i),
        .credit_count_o (credit_count_o)
    );

    // Row: {en,dirw,cvld,rdreq,wrreq,rddone,wrresp,tack} {rd_gnt,wr_gnt,ack} count txn_valid
    localparam int NV = 18;
    localparam logic [17:0] TBL [NV] = '{
        {8'b10100000, 3'b000, 6'd1, 1'b0},  // R2 credit in
        {8'b10100000, 3'b000, 6'd2, 1'b0},  // R2
        {8'b10010000, 3'b100, 6'd1, 1'b0},  // R4 metered read spends
        {8'b10110000, 3'b100, 6'd1, 1'b0},  // R5 credit and spend
        {8'b10001000, 3'b010, 6'd1, 1'b0},  // R6 unmetered write
        {8'b10000100, 3'b000, 6'd1, 1'b1},  // R7 read done queued
        {8'b10000010, 3'b000, 6'd1, 1'b1},  // R7 write resp ignored, R8 held
        {8'b10000001, 3'b000, 6'd1, 1'b0},  // R8 ack drains
        {8'b10010000, 3'b100, 6'd0, 1'b0},  // R4
        {8'b10010000, 3'b000, 6'd0, 1'b0},  // R4 empty bank refuses
        {8'b11011000, 3'b100, 6'd0, 1'b0},  // R4/R6 mode swap
        {8'b11101000, 3'b000, 6'd1, 1'b0},  // R4 refused, R2 credit taken
        {8'b11001000, 3'b010, 6'd0, 1'b0},  // R4 metered write
        {8'b11000110, 3'b000, 6'd0, 1'b1},  // R7 only write resp counts
        {8'b11000010, 3'b000, 6'd0, 1'b1},  // R9 second pending
        {8'b11000001, 3'b000, 6'd0, 1'b1},  // R9 one left
        {8'b11000001, 3'b000, 6'd0, 1'b0},  // R9 drained
        {8'b00111111, 3'b000, 6'd0, 1'b0}   // R10 disabled quiet
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] s);
        @(negedge clk);
        {cfg_enable, cfg_dir_write, crd_valid_i, rd_req_i, wr_req_i,
         rd_done_i, wr_resp_i, txn_ack_i} = s;
        #2;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state, metered request refused
        drive(8'b10010000);
        chk("R1", "count", credit_count_o, 0);
        chk("R1", "crd_ack", crd_ack_o, 0);
        chk("R1", "txn_valid", txn_valid_o, 0);
        chk("R1", "rd_gnt", rd_gnt_o, 0);
        after_edge();

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i][17:10]);
            chk("vec", $sformatf("rd_gnt v%0d", i), rd_gnt_o, TBL[i][9]);
            chk("vec", $sformatf("wr_gnt v%0d", i), wr_gnt_o, TBL[i][8]);
            chk("vec", $sformatf("crd_ack v%0d", i), crd_ack_o, TBL[i][7]);
            after_edge();
            chk("vec", $sformatf("count v%0d", i), credit_count_o, int'(TBL[i][6:1]));
            chk("vec", $sformatf("txn_valid v%0d", i), txn_valid_o, TBL[i][0]);
        end

        // R3 fill under steady offer, write mode
        for (int i = 0; i < 40; i++) begin
            drive(8'b11100000);
            after_edge();
        end
        chk("R3", "count at ceiling", credit_count_o, 32);
        drive(8'b11100000);
        chk("R3", "crd_ack when full", crd_ack_o, 1);
        after_edge();
        chk("R3", "count holds at ceiling", credit_count_o, 32);

        // R5/R4 spend at full with offer present: ack high, count drops
        drive(8'b11101000);
        chk("R4", "wr_gnt at full", wr_gnt_o, 1);
        chk("R3", "crd_ack during spend", crd_ack_o, 1);
        after_edge();
        chk("R4", "count after spend at full", credit_count_o, 31);
        drive(8'b11100000);
        chk("R3", "crd_ack released", crd_ack_o, 0);
        after_edge();
        chk("R2", "refill to ceiling", credit_count_o, 32);

        // R10 disable with credits and pending completions outstanding
        drive(8'b11000010);
        after_edge();
        drive(8'b11000010);
        after_edge();
        chk("R9", "pending before disable", txn_valid_o, 1);
        drive(8'b00101000);
        chk("R10", "wr_gnt off", wr_gnt_o, 0);
        chk("R10", "crd_ack off", crd_ack_o, 0);
        chk("R10", "txn_valid off", txn_valid_o, 0);
        after_edge();
        chk("R10", "count cleared", credit_count_o, 0);
        drive(8'b11000000);
        chk("R10", "pending flushed", txn_valid_o, 0);
        after_edge();
        chk("R10", "count stays zero", credit_count_o, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule